// File: doc/BRIEF.md
# Packed-Lane Narrowing Right Shift

This block is a purely combinational datapath in a 256-bit vector unit. It takes every wide element of a source vector, shifts it right by an amount held in the matching element of a second vector, keeps only the lower half of the shifted value, and packs these narrowed values together. The vector is handled as two independent 128-bit lanes. Each lane's packed results occupy that lane's lower 64 bits, and its upper 64 bits are driven to zero.

Three element widths W are available: 16, 32 and 64 bits, narrowed to 8, 16 and 32 bits. There are two shift kinds. A logical shift fills vacated bits with zeros. An arithmetic shift fills them with copies of the element's sign bit. There is no 128-bit source width. The enclosing pipeline registers the operands and the result, so the block itself holds no state.

Top module: `vec_narrow_shr`

## Requirements
- R1: Lane 0 (source bits [127:0]) produces only result bits [63:0]. Lane 1 (source bits [255:128]) produces only result bits [191:128]. One lane's source never affects the other lane's result.
- R2: Result bits [127:64] and [255:192] are zero for every input.
- R3: The shift amount for source element k of width W is the element at the same position in `amt_b`, read as unsigned and reduced modulo W. Only its low log2(W) bits matter, and all higher bits of that element are ignored.
- R4: When `arith` is 0, the element is treated as unsigned, and the vacated high bits are zeros.
- R5: When `arith` is 1, the element is treated as two's-complement signed, and the vacated high bits are copies of its bit W-1.
- R6: Each shifted element keeps its low W/2 bits. Source element k of a lane (starting at lane bit k*W) lands at lane bit k*W/2.
- R7: `size_sel` selects the width: 0 means W=16, 1 means W=32, 2 means W=64. The value 3 gives an all-zero result.
- R8: `arith` chooses the shift kind only. With a non-negative source element, both kinds give the same result.
- R9: The output is a function of the current inputs only, and it settles within the same cycle the inputs change.
- R10: A shift amount of 0 returns the element's low half unchanged. A shift amount of W-1 returns the sign bit alone in logical mode, and all-ones or all-zeros by sign in arithmetic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 256 | Source vector of wide elements |
| amt_b | input | 256 | Per-element shift amounts, same element layout as src_a |
| size_sel | input | 2 | Element width select (0:16, 1:32, 2:64, 3:zero result) |
| arith | input | 1 | 1 selects arithmetic shift, 0 selects logical shift |
| result | output | 256 | Packed narrowed result, upper half of each lane zero |

## Verification
Narrowing and packing for lane 0 and lane 1 happen in the same evaluation, alongside the forced zeroing of each lane's upper half. A fault in lane indexing or packing can therefore spill one lane's data into the other lane or into a zeroed half. The bench provokes this with unlike, frequently negative patterns in both lanes and with only one lane populated at a time. It judges every cycle by comparing the full 256-bit word against a behavioural model that extends, shifts and truncates each element bit by bit.

// File: rtl/vec_narrow_shr.sv
module vec_narrow_shr #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128,
  parameter int MIN_W  = 16,
  parameter int NMODES = 3
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] amt_b,
  input  logic [1:0]       size_sel,
  input  logic             arith,
  output logic [VEC_W-1:0] result
);
  localparam int NLANE = VEC_W / LANE_W;
  localparam int HALF  = LANE_W / 2;

  logic [NMODES-1:0][VEC_W-1:0] mode_res;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int W   = MIN_W << m;
    localparam int SW  = $clog2(W);
    localparam int NEL = LANE_W / W;
    localparam int NW  = W / 2;
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      for (genvar e = 0; e < NEL; e++) begin : g_el
        logic [W-1:0]  elem;
        logic [SW-1:0] sh;
        logic [W-1:0]  lsr;
        logic [W-1:0]  asr;
        assign elem = src_a[l*LANE_W + e*W +: W];
        assign sh   = amt_b[l*LANE_W + e*W +: SW];
        assign lsr  = elem >> sh;
        assign asr  = $signed(elem) >>> sh;
        assign mode_res[m][l*LANE_W + e*NW +: NW] = arith ? asr[NW-1:0] : lsr[NW-1:0];

        always_comb begin
          if (!$isunknown({elem, sh})) begin
            a_r10_zero_shift_keeps_low: assert (sh != '0 || lsr[NW-1:0] == elem[NW-1:0]);
            a_r8_kinds_agree_nonneg:    assert (elem[W-1] || asr == lsr);
            a_r5_full_shift_sign:       assert (sh != SW'(W-1) || asr == {W{elem[W-1]}});
            a_r4_full_shift_zero_fill:  assert (sh != SW'(W-1) || lsr == W'(elem[W-1]));
          end
        end
      end
      assign mode_res[m][l*LANE_W + HALF +: HALF] = '0;
    end
  end

  always_comb begin
    result = '0;
    for (int k = 0; k < NMODES; k++)
      if (size_sel == 2'(k)) result = mode_res[k];
  end

  always_comb begin
    if (!$isunknown({size_sel, arith, src_a, amt_b})) begin
      for (int l = 0; l < NLANE; l++)
        a_r2_upper_half_zero: assert (result[l*LANE_W + HALF +: HALF] == '0);
      a_r7_reserved_code_zero: assert (size_sel != 2'd3 || result == '0);
    end
  end
endmodule

// File: tb/vec_narrow_shr_bench.sv
module vec_narrow_shr_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [255:0] src_a = '0;
  logic [255:0] amt_b = '0;
  logic [1:0]   size_sel = 2'd0;
  logic         arith = 1'b0;
  logic [255:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_narrow_shr u_vec_narrow_shr (
    .src_a(src_a), .amt_b(amt_b), .size_sel(size_sel), .arith(arith), .result(result)
  );

  function automatic logic [255:0] ref_model(input logic [255:0] a, input logic [255:0] b,
                                             input logic [1:0] sel, input logic ar);
    logic [255:0] r;
    int w;
    r = '0;
    if (sel == 2'd3) return r;
    w = 16 << sel;
    for (int lane = 0; lane < 2; lane++) begin
      for (int k = 0; k < 128 / w; k++) begin
        logic [127:0] e;
        int base;
        int s;
        e = '0;
        base = lane * 128 + k * w;
        for (int i = 0; i < w; i++) e[i] = a[base + i];
        if (ar && e[w-1]) for (int i = w; i < 128; i++) e[i] = 1'b1;
        s = int'(b[base +: 7]) % w;
        e = e >> s;
        for (int i = 0; i < w / 2; i++) r[lane * 128 + k * (w / 2) + i] = e[i];
      end
    end
    return r;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] fill_amt(input int w, input int val);
    logic [255:0] v;
    v = '0;
    for (int k = 0; k < 256 / w; k++) v[k*w +: 8] = 8'(val);
    return v;
  endfunction

  task automatic apply(input logic [255:0] a, input logic [255:0] b, input logic [1:0] sel,
                       input logic ar, input string tag);
    logic [255:0] exp;
    @(posedge clk);
    src_a = a; amt_b = b; size_sel = sel; arith = ar;
    @(negedge clk);
    exp = ref_model(a, b, sel, ar);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d arith=%0d actual=%h expected=%h", tag, sel, ar, result, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== '0) begin
      errors++;
      $display("FAIL R9 idle inputs actual=%h expected=%h", result, 256'd0);
    end
    for (int m = 0; m < 3; m++) begin
      int w;
      w = 16 << m;
      apply({256{1'b1}}, '0, 2'(m), 1'b0, "R10 zero shift");
      apply({8{32'h8421_F0C3}}, fill_amt(w, w - 1), 2'(m), 1'b1, "R5 R10 arith full shift");
      apply({8{32'h8421_F0C3}}, fill_amt(w, w - 1), 2'(m), 1'b0, "R4 R10 logic full shift");
      apply({8{32'hC000_8001}}, fill_amt(w, w + 1), 2'(m), 1'b1, "R3 modulo amount");
      apply({8{32'h7654_3210}}, fill_amt(w, 3), 2'(m), 1'b1, "R8 nonneg arith");
      apply({128'd0, {4{32'hDEAD_BEEF}}}, fill_amt(w, 2), 2'(m), 1'b1, "R1 lane0 only");
      apply({{4{32'hF00D_CAFE}}, 128'd0}, fill_amt(w, 5), 2'(m), 1'b1, "R1 lane1 only");
      apply({8{32'h0123_4567}}, fill_amt(w, 4), 2'(m), 1'b0, "R6 truncate pack");
    end
    apply({256{1'b1}}, rand256(), 2'd3, 1'b1, "R7 reserved size");
    apply({256{1'b1}}, rand256(), 2'd3, 1'b0, "R7 reserved size logic");
    for (int it = 0; it < 40; it++)
      for (int m = 0; m < 4; m++) begin
        apply(rand256(), rand256(), 2'(m), 1'b0, "R2 R4 R7 random logic");
        apply(rand256(), rand256(), 2'(m), 1'b1, "R2 R5 R7 random arith");
      end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule